// File: doc/BRIEF.md
# Stack Push/Pop Bus Sequencer

This block carries out a 16-bit register push or pop onto a stack held in byte-wide memory. A single start pulse selects the direction and, for a push, supplies the 16-bit value. The block then runs a fixed series of four machine cycles. The first two are generic instruction fetch cycles. The last two move the two data bytes. The block owns the 16-bit stack pointer. For a pop it returns the assembled 16-bit value together with a one-cycle valid pulse.

Each machine cycle runs through its own T-state engine. The engine puts out an address and then raises a memory request together with a read or a write strobe. It samples a wait input so that slow memory can stretch the cycle. A pop reads upward from the stack pointer and takes the low byte first. A push moves the pointer down before each write and sends the high byte first.

Top module: `stk_seq`

## Requirements
- R1: After a synchronous reset, busy_o, pop_vld_o, mem_req_o, mem_rd_o and mem_wr_o are low, and sp_o equals the parameter SP_INIT.
- R2: An accepted start produces exactly four memory accesses. The first two are fetches: fetch_o is high and the read strobe is used. The last two are data accesses.
- R3: A pop reads the low byte at SP and then the high byte at SP+1. pop_data_o then holds {high, low}, and pop_vld_o is high for exactly one cycle, the cycle in which busy_o falls. A push never raises pop_vld_o.
- R4: A push writes wdata_i[15:8] at SP-1 and then wdata_i[7:0] at SP-2. Both use the write strobe.
- R5: When the operation ends, sp_o equals the starting SP+2 after a pop and the starting SP-2 after a push, with wraparound modulo 2^16. While busy_o is low, sp_o does not change.
- R6: A machine cycle drives its address for one cycle (T1) before the strobes. mem_req_o and the one strobe that matches the access are then high for T2 and T3, which is two cycles when no wait is added. mem_rd_o and mem_wr_o are never high together.
- R7: wait_i is sampled at the clock edge that ends T2 and at the edge that ends each wait state. Each high sample adds one cycle to the strobe. The address stays stable, and the order and contents of the accesses do not change.
- R8: busy_o goes high in the cycle after a start is accepted. It stays high until the cycle after the last machine cycle completes. A start that arrives while busy_o is high is ignored, whatever the values on push_i and wdata_i.
- R9: If start_i is high in the cycle in which busy_o has just fallen, a new operation is accepted at the next edge. This is the same cycle in which pop_vld_o shows the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled while idle |
| push_i | input | 1 | 1 = push, 0 = pop |
| wdata_i | input | 16 | Value to push |
| busy_o | output | 1 | Operation in progress |
| pop_data_o | output | 16 | Last popped value |
| pop_vld_o | output | 1 | One-cycle pulse when a pop finishes |
| sp_o | output | 16 | Stack pointer |
| mem_addr_o | output | 16 | Memory address (zero for fetches) |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, sampled at the end of T3 |
| mem_req_o | output | 1 | Memory request strobe |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| fetch_o | output | 1 | Marks a fetch machine cycle |
| wait_i | input | 1 | Wait-state request |

## Verification
Two things can fall in the same cycle: the end of one operation, shown by the pop_vld_o pulse and the fall of busy_o, and the acceptance of the next start. The bench provokes this by holding start_i high across the end of a pop. It then judges that the popped value and its single pulse are correct in that cycle, that busy_o rises again one edge later, and that the second operation produces its own correct four accesses and final pointer. A second case raises start with the opposite direction in the middle of an operation. It judges from the access log and the pointer that the request left no trace.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    MC_FETCH = 2'd0,
    MC_READ  = 2'd1,
    MC_WRITE = 2'd2
  } mc_kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_T3   = 3'd4
  } tstate_e;
endpackage

// File: rtl/stk_sptr.sv
module stk_sptr #(
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_dn_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= SP_INIT;
    end else if (inc_i && !dec_i) begin
      sp_q <= sp_q + ONE;
    end else if (dec_i && !inc_i) begin
      sp_q <= sp_q - ONE;
    end
  end

  assign sp_o    = sp_q;
  assign sp_dn_o = sp_q - ONE;
endmodule

// File: rtl/stk_mcyc.sv
module stk_mcyc
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  mc_kind_e      kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wbyte_i,
  output logic          done_o,
  output logic [DW-1:0] rbyte_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          fetch_o,
  input  logic          wait_i
);
  tstate_e       ts_q;
  mc_kind_e      kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] rb_q;
  logic          done_q, req_q, rd_q, wr_q, fetch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q    <= TS_IDLE;
      kind_q  <= MC_FETCH;
      addr_q  <= '0;
      wd_q    <= '0;
      rb_q    <= '0;
      done_q  <= 1'b0;
      req_q   <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ts_q)
        TS_IDLE: begin
          if (go_i) begin
            ts_q    <= TS_T1;
            kind_q  <= kind_i;
            addr_q  <= addr_i;
            wd_q    <= wbyte_i;
            fetch_q <= (kind_i == MC_FETCH);
          end
        end
        TS_T1: begin
          ts_q  <= TS_T2;
          req_q <= 1'b1;
          rd_q  <= (kind_q != MC_WRITE);
          wr_q  <= (kind_q == MC_WRITE);
        end
        TS_T2, TS_TW: begin
          ts_q <= wait_i ? TS_TW : TS_T3;
        end
        TS_T3: begin
          ts_q    <= TS_IDLE;
          req_q   <= 1'b0;
          rd_q    <= 1'b0;
          wr_q    <= 1'b0;
          fetch_q <= 1'b0;
          rb_q    <= mem_rdata_i;
          done_q  <= 1'b1;
        end
        default: ts_q <= TS_IDLE;
      endcase
    end
  end

  assign done_o      = done_q;
  assign rbyte_o     = rb_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wd_q;
  assign mem_req_o   = req_q;
  assign mem_rd_o    = rd_q;
  assign mem_wr_o    = wr_q;
  assign fetch_o     = fetch_q;
endmodule

// File: rtl/stk_ctl.sv
module stk_ctl
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NFETCH = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            push_i,
  input  logic [2*DW-1:0] wdata_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [AW-1:0]   sp_dn_i,
  output logic            sp_inc_o,
  output logic            sp_dec_o,
  output logic            go_o,
  output mc_kind_e        kind_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wbyte_o,
  input  logic            done_i,
  input  logic [DW-1:0]   rbyte_i,
  output logic            busy_o,
  output logic [2*DW-1:0] pop_data_o,
  output logic            pop_vld_o
);
  localparam int NMC = NFETCH + 2;
  localparam int IW  = $clog2(NMC);
  localparam logic [IW-1:0] DATA0 = IW'(NFETCH);
  localparam logic [IW-1:0] LAST  = IW'(NMC - 1);

  logic [IW-1:0]   mc_q;
  logic            busy_q, push_q, go_q, vld_q;
  logic [2*DW-1:0] hold_q, pop_q;
  logic [DW-1:0]   lo_q, wb_q;
  logic [AW-1:0]   addr_q;
  mc_kind_e        kind_q;

  logic            first, adv, fin, issue, nx_push, nx_data;
  logic [IW-1:0]   nx_idx;
  logic [2*DW-1:0] nx_hold;
  logic [AW-1:0]   nx_addr;
  mc_kind_e        nx_kind;
  logic [DW-1:0]   nx_wb;

  always_comb begin
    first   = start_i && !busy_q;
    adv     = busy_q && done_i && (mc_q != LAST);
    fin     = busy_q && done_i && (mc_q == LAST);
    issue   = first || adv;
    nx_idx  = first ? '0 : mc_q + IW'(1);
    nx_push = first ? push_i : push_q;
    nx_hold = first ? wdata_i : hold_q;
    nx_data = (nx_idx >= DATA0);
    if (!nx_data) begin
      nx_kind = MC_FETCH;
      nx_addr = '0;
    end else if (nx_push) begin
      nx_kind = MC_WRITE;
      nx_addr = sp_dn_i;
    end else begin
      nx_kind = MC_READ;
      nx_addr = sp_i;
    end
    nx_wb = (nx_idx == DATA0) ? nx_hold[2*DW-1:DW] : nx_hold[DW-1:0];
  end

  assign sp_inc_o = issue && nx_data && !nx_push;
  assign sp_dec_o = issue && nx_data && nx_push;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q   <= '0;
      busy_q <= 1'b0;
      push_q <= 1'b0;
      go_q   <= 1'b0;
      vld_q  <= 1'b0;
      hold_q <= '0;
      pop_q  <= '0;
      lo_q   <= '0;
      wb_q   <= '0;
      addr_q <= '0;
      kind_q <= MC_FETCH;
    end else begin
      go_q  <= issue;
      vld_q <= 1'b0;
      if (issue) begin
        mc_q   <= nx_idx;
        kind_q <= nx_kind;
        addr_q <= nx_addr;
        wb_q   <= nx_wb;
      end
      if (first) begin
        busy_q <= 1'b1;
        push_q <= push_i;
        hold_q <= wdata_i;
      end
      if (adv && (mc_q == DATA0) && !push_q) begin
        lo_q <= rbyte_i;
      end
      if (fin) begin
        busy_q <= 1'b0;
        if (!push_q) begin
          pop_q <= {rbyte_i, lo_q};
          vld_q <= 1'b1;
        end
      end
    end
  end

  assign go_o       = go_q;
  assign kind_o     = kind_q;
  assign addr_o     = addr_q;
  assign wbyte_o    = wb_q;
  assign busy_o     = busy_q;
  assign pop_data_o = pop_q;
  assign pop_vld_o  = vld_q;
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NFETCH = 2,
  parameter logic [AW-1:0] SP_INIT = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            push_i,
  input  logic [2*DW-1:0] wdata_i,
  output logic            busy_o,
  output logic [2*DW-1:0] pop_data_o,
  output logic            pop_vld_o,
  output logic [AW-1:0]   sp_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            mem_req_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            fetch_o,
  input  logic            wait_i
);
  logic [AW-1:0] sp_w, sp_dn_w, addr_w;
  logic          inc_w, dec_w, go_w, done_w;
  mc_kind_e      kind_w;
  logic [DW-1:0] wb_w, rb_w;

  stk_sptr #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
    .clk(clk), .rst(rst), .inc_i(inc_w), .dec_i(dec_w),
    .sp_o(sp_w), .sp_dn_o(sp_dn_w)
  );

  stk_ctl #(.AW(AW), .DW(DW), .NFETCH(NFETCH)) u_ctl (
    .clk(clk), .rst(rst), .start_i(start_i), .push_i(push_i), .wdata_i(wdata_i),
    .sp_i(sp_w), .sp_dn_i(sp_dn_w), .sp_inc_o(inc_w), .sp_dec_o(dec_w),
    .go_o(go_w), .kind_o(kind_w), .addr_o(addr_w), .wbyte_o(wb_w),
    .done_i(done_w), .rbyte_i(rb_w), .busy_o(busy_o),
    .pop_data_o(pop_data_o), .pop_vld_o(pop_vld_o)
  );

  stk_mcyc #(.AW(AW), .DW(DW)) u_mc (
    .clk(clk), .rst(rst), .go_i(go_w), .kind_i(kind_w), .addr_i(addr_w),
    .wbyte_i(wb_w), .done_o(done_w), .rbyte_o(rb_w),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_req_o(mem_req_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .fetch_o(fetch_o), .wait_i(wait_i)
  );

  assign sp_o = sp_w;
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_o,
  input logic          pop_vld_o,
  input logic [AW-1:0] sp_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_req_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o
);
  // R6
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  // R6
  strobe_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o || mem_wr_o) |-> mem_req_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_req_o);

  // R3
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pop_vld_o |=> !pop_vld_o);

  // R3
  vld_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    pop_vld_o |-> $fell(busy_o));

  // R5
  sp_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && $past(!busy_o)) |-> $stable(sp_o));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && $past(mem_req_o)) |-> $stable(mem_addr_o));
endmodule

bind stk_seq stk_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .pop_vld_o(pop_vld_o), .sp_o(sp_o),
  .mem_addr_o(mem_addr_o), .mem_req_o(mem_req_o), .mem_rd_o(mem_rd_o),
  .mem_wr_o(mem_wr_o)
);

// File: tb/sim_stk_seq.sv
`timescale 1ns/1ps
module sim_stk_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        push_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic        busy_o, pop_vld_o, mem_req_o, mem_rd_o, mem_wr_o, fetch_o, wait_i;
  logic [15:0] pop_data_o, sp_o, mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;

  int total = 0;
  int bad = 0;
  int nwait = 0;
  int hi_cnt = 0;
  int n_log = 0;
  int vld_cnt = 0;
  logic [7:0]  mem [256];
  int          lg_kind [8];
  logic [15:0] lg_addr [8];
  logic [7:0]  lg_data [8];
  int          lg_len  [8];
  logic        prev_req = 1'b0;

  always #2.5 clk = ~clk;

  stk_seq #(.SP_INIT(16'h0002)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .push_i(push_i), .wdata_i(wdata_i),
    .busy_o(busy_o), .pop_data_o(pop_data_o), .pop_vld_o(pop_vld_o), .sp_o(sp_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_req_o(mem_req_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .fetch_o(fetch_o), .wait_i(wait_i)
  );

  // memory model and wait generator
  assign mem_rdata_i = fetch_o ? 8'hDD : mem[mem_addr_o[7:0]];
  assign wait_i = mem_req_o && (hi_cnt < nwait);
  always @(posedge clk) hi_cnt <= mem_req_o ? hi_cnt + 1 : 0;

  // bus monitor
  always @(negedge clk) begin
    if (mem_req_o && !prev_req && n_log < 8) begin
      lg_kind[n_log] = fetch_o ? 0 : (mem_wr_o ? 2 : 1);
      lg_addr[n_log] = mem_addr_o;
      lg_data[n_log] = mem_wr_o ? mem_wdata_o : mem_rdata_i;
      lg_len[n_log]  = 0;
    end
    if (mem_req_o && n_log < 8) lg_len[n_log] = lg_len[n_log] + 1;
    if (mem_wr_o) mem[mem_addr_o[7:0]] = mem_wdata_o;
    if (!mem_req_o && prev_req) n_log = n_log + 1;
    if (pop_vld_o) vld_cnt = vld_cnt + 1;
    prev_req = mem_req_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic verify(input bit psh, input logic [15:0] val, input int nw,
                        input logic [15:0] sp0, input logic [15:0] exp_pop);
    chk(n_log == 4, "R2 access count", n_log, 4);
    chk(lg_kind[0] == 0 && lg_kind[1] == 0, "R2 fetch kinds", {lg_kind[0][15:0], lg_kind[1][15:0]}, 0);
    for (int i = 0; i < 4; i++) chk(lg_len[i] == 2 + nw, "R6 R7 strobe length", lg_len[i], 2 + nw);
    if (psh) begin
      chk(lg_kind[2] == 2 && lg_addr[2] == sp0 - 16'd1 && lg_data[2] == val[15:8],
          "R4 high write", {lg_kind[2][7:0], lg_addr[2], lg_data[2]}, {8'd2, sp0 - 16'd1, val[15:8]});
      chk(lg_kind[3] == 2 && lg_addr[3] == sp0 - 16'd2 && lg_data[3] == val[7:0],
          "R4 low write", {lg_kind[3][7:0], lg_addr[3], lg_data[3]}, {8'd2, sp0 - 16'd2, val[7:0]});
      chk(vld_cnt == 0, "R3 no valid on push", vld_cnt, 0);
      chk(sp_o == sp0 - 16'd2, "R5 push sp", sp_o, sp0 - 16'd2);
    end else begin
      chk(lg_kind[2] == 1 && lg_addr[2] == sp0, "R3 low read", {lg_kind[2][15:0], lg_addr[2]}, {16'd1, sp0});
      chk(lg_kind[3] == 1 && lg_addr[3] == sp0 + 16'd1, "R3 high read", {lg_kind[3][15:0], lg_addr[3]}, {16'd1, sp0 + 16'd1});
      chk(pop_data_o == exp_pop, "R3 pop data", pop_data_o, exp_pop);
      chk(vld_cnt == 1, "R3 valid pulse count", vld_cnt, 1);
      chk(sp_o == sp0 + 16'd2, "R5 pop sp", sp_o, sp0 + 16'd2);
    end
  endtask

  // one operation; extra>0 raises start with the opposite direction while busy (R8)
  task automatic run_op(input bit psh, input logic [15:0] val, input int nw,
                        input int extra, input logic [15:0] exp_pop);
    logic [15:0] sp0;
    sp0 = sp_o;
    nwait = nw; n_log = 0; vld_cnt = 0;
    push_i = psh; wdata_i = val; start_i = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    for (int k = 0; k < extra; k++) begin
      push_i = ~psh; wdata_i = 16'hFFFF;
      @(negedge clk);
    end
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    verify(psh, val, nw, sp0, exp_pop);
  endtask

  // R9: start held high across the end of a pop
  task automatic run_b2b(input logic [15:0] exp1, input logic [15:0] exp2);
    logic [15:0] sp0;
    sp0 = sp_o;
    nwait = 0;
    push_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    chk(pop_vld_o == 1'b1 && pop_data_o == exp1, "R9 first result at handover",
        {15'd0, pop_vld_o, pop_data_o}, {16'd1, exp1});
    @(negedge clk);
    chk(busy_o == 1'b1, "R9 second start accepted", busy_o, 1);
    start_i = 1'b0; n_log = 0; vld_cnt = 0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    verify(1'b0, 16'h0000, 0, sp0 + 16'd2, exp2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(busy_o == 0 && pop_vld_o == 0, "R1 reset flags", {busy_o, pop_vld_o}, 0);
    chk(mem_req_o == 0 && mem_rd_o == 0 && mem_wr_o == 0, "R1 reset strobes",
        {mem_req_o, mem_rd_o, mem_wr_o}, 0);
    chk(sp_o == 16'h0002, "R1 reset sp", sp_o, 16'h0002);
    run_op(1'b1, 16'hA1B2, 0, 0, 16'h0000);   // sp 2 -> 0
    run_op(1'b1, 16'hC3D4, 2, 0, 16'h0000);   // sp 0 -> FFFE (wrap, R5)
    run_op(1'b0, 16'h0000, 1, 0, 16'hC3D4);   // sp FFFE -> 0 (wrap, R7 waits)
    run_op(1'b1, 16'h5566, 0, 3, 16'h0000);   // R8 start ignored while busy
    run_b2b(16'h5566, 16'hA1B2);              // R9 sp FFFE -> 0 -> 2
    run_op(1'b0, 16'h0000, 3, 0, 16'h0000);   // R7 long waits, reads 2,3
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule